// File: doc/BRIEF.md
# Serial Management Bus Master

This block turns one register access request at a time into a serial management frame of the clause-22 kind. It drives a management clock (MDC) produced by dividing the system clock, and a data line split into an output value, an output enable and an input value, so that the chip's pad ring can build the bidirectional MDIO pin. A request names one of 32 PHY devices, one of 32 registers inside it, and either a 16-bit word to write or a read.

Every access is 64 MDC periods long. It starts with 32 ones, then a start pair, an opcode, the two addresses, a turnaround pair and the 16-bit data word. On a read the master lets go of the line for the turnaround and the data bits, and it samples the PHY's reply on rising MDC. A reply of all ones means no PHY drove the line, and this raises a no-response flag. The MDC half period comes from a divider register. That register resets to the slowest safe value, and it can never be set below the limit that keeps MDC at or under the rate allowed for the configured system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, mdc, mdio_oe, no_resp and rd_data are all 0, and mdio_o is 1.
- R2: A request with req_valid high is taken only while busy is low. busy rises on the clock after that. A request presented while busy is high has no effect on the frame in flight or on any later output.
- R3: busy stays high for exactly 128*D clocks, where D is the effective divide value. It then falls in the same cycle that done is high, and done lasts one clock.
- R4: While busy is high, mdc is low for the first D clocks and then alternates every D clocks (period 2*D). While busy is low, mdc is low.
- R5: The effective divide value resets to MIN_DIV = ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)), which is 4 with the defaults (2 MHz from 16 MHz). A cfg_div write below MIN_DIV, including 0, sets MIN_DIV. A write made while busy is high is ignored.
- R6: On a write, MDIO frame bit k (k = 0..63) is presented during MDC period k with mdio_oe high throughout. Bits 0-31 are ones. Then come start bits 0,1, opcode 0,1, req_phy MSB first, req_reg MSB first, turnaround 1,0, and req_wdata MSB first.
- R7: On a read the opcode bits are 1,0. mdio_oe is low from frame bit 46 (the first turnaround bit) to the end of the frame, and high before that.
- R8: On a read, mdio_i is sampled at each rising MDC edge of frame bits 48-63, MSB first. The word appears on rd_data in the cycle where done is high and is held until the next read completes.
- R9: When a read completes, no_resp goes high if the word read is 0xFFFF and low otherwise. When a write completes, no_resp goes low.
- R10: mdio_o and mdio_oe change only in the cycle where mdc falls, or when a frame starts or ends. They are stable while mdc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div_wr | input | 1 | Strobe to load cfg_div into the divider register |
| cfg_div | input | DIV_W | Requested MDC half period in system clocks |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse when a frame ends |
| rd_data | output | 16 | Word from the last completed read |
| no_resp | output | 1 | The last completed read returned all ones |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Counted from the clock edge that takes a request, busy is due one clock later, and MDC's first rise is due D clocks after busy. Frame bit k occupies clocks 2*D*k to 2*D*k+2*D-1 of the busy window, and done, rd_data and no_resp are all due at clock 128*D. The bench reference model keeps its own cycle index from the acceptance edge and recomputes each of these outputs from that index at every falling clock edge. It also drives the PHY reply for the bit period the same index gives, so each read sample lands on the edge the index predicts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam logic [5:0] TA_IDX   = 6'd46;
    localparam logic [5:0] DATA_IDX = 6'd48;
    localparam logic [5:0] LAST_IDX = 6'd63;

    localparam logic [1:0] START_BITS = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;
    localparam logic [1:0] TA_READ    = 2'b11;

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        rd;
        logic [5:0]  bidx;
        logic [63:0] sh;
        logic [15:0] rx;
        logic [15:0] rd_data;
        logic        no_resp;
    } frm_state_t;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cd_state_t;

    cd_state_t cd_d, cd_q;

    always_comb begin
        cd_d     = cd_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            cd_d.cnt = '0;
            cd_d.mdc = 1'b0;
        end else if (cd_q.cnt == div - 1'b1) begin
            cd_d.cnt = '0;
            cd_d.mdc = ~cd_q.mdc;
            rise_stb = ~cd_q.mdc;
            fall_stb = cd_q.mdc;
        end else begin
            cd_d.cnt = cd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign mdc = cd_q.mdc;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        no_resp
);

    frm_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.rd   = ~req_write;
                st_d.bidx = '0;
                st_d.rx   = '0;
                st_d.sh   = {32'hFFFF_FFFF, START_BITS,
                             (req_write ? OP_WRITE : OP_READ),
                             req_phy, req_reg,
                             (req_write ? TA_WRITE : TA_READ),
                             req_wdata};
            end
        end else begin
            if (rise_stb && st_q.rd && (st_q.bidx >= DATA_IDX)) begin
                st_d.rx = {st_q.rx[14:0], mdio_i};
            end
            if (fall_stb) begin
                if (st_q.bidx == LAST_IDX) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    if (st_q.rd) begin
                        st_d.rd_data = st_q.rx;
                        st_d.no_resp = (st_q.rx == 16'hFFFF);
                    end else begin
                        st_d.no_resp = 1'b0;
                    end
                end else begin
                    st_d.bidx = st_q.bidx + 1'b1;
                    st_d.sh   = {st_q.sh[62:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign mdio_o  = st_q.busy ? st_q.sh[63] : 1'b1;
    assign mdio_oe = st_q.busy & ~(st_q.rd & (st_q.bidx >= TA_IDX));
    assign rd_data = st_q.rd_data;
    assign no_resp = st_q.no_resp;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int SYS_CLK_HZ = 16_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_div_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             no_resp,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    localparam int               MIN_DIV_I = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam logic [DIV_W-1:0] MIN_DIV   = DIV_W'(MIN_DIV_I);

    logic [DIV_W-1:0] div_d, div_q;
    logic             rise_stb, fall_stb;

    always_comb begin
        div_d = div_q;
        if (cfg_div_wr && !busy) begin
            div_d = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= MIN_DIV;
        else        div_q <= div_d;
    end

    mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data),
        .no_resp   (no_resp)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int SYS_CLK_HZ = 16_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        no_resp,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    localparam int          MIN_DIV_I = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam logic [15:0] MIN_DIV_L = 16'(MIN_DIV_I);

    logic        mdc_prev;
    logic [15:0] level_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_prev  <= 1'b0;
            level_len <= '0;
        end else begin
            mdc_prev <= mdc;
            if (mdc != mdc_prev)       level_len <= 16'd1;
            else if (level_len != '1)  level_len <= level_len + 16'd1;
        end
    end

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r5_half_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != mdc_prev) |-> (level_len >= MIN_DIV_L));

    a_r9_flag_means_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> (rd_data == 16'hFFFF));

    a_r10_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .no_resp   (no_resp),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    localparam int MIN_D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_div_wr = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic        r_valid = 1'b0;
    logic        r_write = 1'b0;
    logic [4:0]  r_phy = '0;
    logic [4:0]  r_reg = '0;
    logic [15:0] r_wdata = '0;
    logic        busy, done, no_resp, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i_r = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    // reference model state
    bit          mb = 0;
    int          mt = 0;
    int          md = MIN_D;
    bit          mrd = 0;
    bit          fq[$];
    logic [15:0] phy_resp = 16'h0000;
    bit          phy_present = 1;
    logic [15:0] m_resp;
    bit          m_present;
    logic [15:0] e_rd = 16'h0000;
    bit          e_nr = 0;

    always #2.5 clk = ~clk;

    mdio_master dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_div_wr (cfg_div_wr),
        .cfg_div    (cfg_div),
        .req_valid  (r_valid),
        .req_write  (r_write),
        .req_phy    (r_phy),
        .req_reg    (r_reg),
        .req_wdata  (r_wdata),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .no_resp    (no_resp),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i_r)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic void push_field(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) fq.push_back(v[i]);
    endfunction

    // per-cycle reference model and comparison
    always @(negedge clk) begin
        int  len;
        int  idx;
        bit  eb, ed, emdc, eo, eoe, idle_now;
        if (rst_n && started) begin
            len = 128 * md;
            eb  = mb && (mt < len);
            ed  = mb && (mt == len);
            if (eb) begin
                idx  = mt / (2 * md);
                emdc = ((mt / md) % 2) == 1;
                eo   = fq[idx];
                eoe  = !(mrd && idx >= 46);
            end else begin
                idx = 0; emdc = 0; eo = 1; eoe = 0;
            end
            if (ed) begin
                if (mrd) begin
                    e_rd = m_present ? m_resp : 16'hFFFF;
                    e_nr = (e_rd == 16'hFFFF);
                end else begin
                    e_nr = 0;
                end
            end
            mdio_i_r = (eb && mrd && idx >= 48 && m_present) ? m_resp[15 - (idx - 48)] : 1'b1;

            chk({15'd0, busy},    {15'd0, eb},   "R2 R3 busy");
            chk({15'd0, done},    {15'd0, ed},   "R3 done");
            chk({15'd0, mdc},     {15'd0, emdc}, "R4 R5 mdc");
            chk({15'd0, mdio_oe}, {15'd0, eoe},  "R6 R7 mdio_oe");
            if (eoe || !eb) chk({15'd0, mdio_o}, {15'd0, eo}, "R6 R10 mdio_o");
            chk(rd_data,          e_rd,          "R8 rd_data");
            chk({15'd0, no_resp}, {15'd0, e_nr}, "R9 no_resp");

            idle_now = !eb;
            if (idle_now && cfg_div_wr) md = (cfg_div < MIN_D) ? MIN_D : int'(cfg_div);
            if (mb) begin
                if (mt == len) mb = 0;
                else mt++;
            end
            if (idle_now && r_valid) begin
                mb = 1; mt = 0; mrd = !r_write;
                m_resp = phy_resp; m_present = phy_present;
                fq.delete();
                for (int i = 0; i < 32; i++) fq.push_back(1'b1);
                fq.push_back(1'b0); fq.push_back(1'b1);
                if (r_write) begin fq.push_back(1'b0); fq.push_back(1'b1); end
                else         begin fq.push_back(1'b1); fq.push_back(1'b0); end
                push_field({11'd0, r_phy}, 5);
                push_field({11'd0, r_reg}, 5);
                if (r_write) begin fq.push_back(1'b1); fq.push_back(1'b0); end
                else         begin fq.push_back(1'b1); fq.push_back(1'b1); end
                push_field(r_wdata, 16);
            end
        end
    end

    task automatic set_div(input logic [7:0] v);
        @(posedge clk); #1;
        cfg_div_wr = 1'b1; cfg_div = v;
        @(posedge clk); #1;
        cfg_div_wr = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] resp, input bit present,
                          input bit inject);
        phy_resp = resp; phy_present = present;
        @(posedge clk); #1;
        r_valid = 1'b1; r_write = wr; r_phy = phy; r_reg = ra; r_wdata = wd;
        @(posedge clk); #1;
        r_valid = 1'b0;
        if (inject) begin
            // R2: request while busy must be ignored; R5: divider write while busy ignored
            repeat (40) @(posedge clk);
            #1;
            r_valid = 1'b1; r_write = ~wr; r_phy = ~phy; r_reg = ~ra; r_wdata = ~wd;
            cfg_div_wr = 1'b1; cfg_div = 8'd9;
            @(posedge clk); #1;
            r_valid = 1'b0; cfg_div_wr = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({15'd0, busy},    16'd0, "R1 busy");
        chk({15'd0, done},    16'd0, "R1 done");
        chk({15'd0, mdc},     16'd0, "R1 mdc");
        chk({15'd0, mdio_oe}, 16'd0, "R1 mdio_oe");
        chk({15'd0, mdio_o},  16'd1, "R1 mdio_o");
        chk({15'd0, no_resp}, 16'd0, "R1 no_resp");
        chk(rd_data,          16'd0, "R1 rd_data");
        started = 1;

        access(1, 5'd1,  5'd31, 16'hA5C3, 16'h0000, 1, 0); // R6 write, reset divider R5
        access(0, 5'd3,  5'd2,  16'h0000, 16'h1234, 1, 0); // R7 R8 read
        access(0, 5'd31, 5'd31, 16'h0000, 16'h0000, 0, 0); // R9 absent PHY
        access(1, 5'd0,  5'd4,  16'h0F0F, 16'h0000, 1, 0); // R9 cleared by write
        set_div(8'd0);                                      // R5 zero clamps
        access(0, 5'd16, 5'd9,  16'h0000, 16'h8001, 1, 0);
        set_div(8'd6);                                      // R5 legal value
        access(1, 5'd21, 5'd10, 16'h5A5A, 16'h0000, 1, 1);  // R2 ignored request
        access(0, 5'd2,  5'd1,  16'h0000, 16'h7FFE, 1, 0);  // divider still 6
        set_div(8'd3);                                      // R5 below floor
        access(0, 5'd7,  5'd0,  16'h0000, 16'hFFFF, 1, 0);  // R9 PHY returns all ones
        access(0, 5'd7,  5'd0,  16'h0000, 16'h0001, 1, 0);  // R9 cleared by read
        repeat (5) @(posedge clk);
        report();
    end

endmodule